// File: doc/BRIEF.md
# NAND Address Cycle Sequencer

This block turns one NAND access request into the ordered series of address-latch bytes a flash device expects. On a start pulse it captures a page number and four configuration flags: whether the column phase is present, whether the page phase is present, whether the device has 2048-byte pages (otherwise 512), and whether the device is high density. It then delivers the bytes one at a time on a valid/ready output stream. The column bytes are always zero because transfers always cover a whole page. The page bytes follow, least significant first.

The caller sets the high-density flag when the device is at or above the size that needs a third row byte: 256 MiB for 2048-byte-page parts and 64 MiB for 512-byte-page parts. The final byte of a sequence carries a last marker, so the downstream latch logic knows when to wait for the device. After the final byte is accepted the block pulses `done_o` for one cycle. Command issue and data movement are handled elsewhere.

Back-pressure rules: the block raises `addr_valid_o` with a byte and holds the byte and its last marker unchanged until `addr_ready_i` is seen high at a rising edge. A transfer occurs on every edge where both are high. The next byte, if any, is presented in the cycle that follows a transfer. `addr_ready_i` may be high at any time, including when no byte is offered.

Top module: `nand_addr_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `addr_valid_o`, `done_o` and `busy_o` are low.
- R2: When the column phase is present, the sequence begins with column bytes of value 0x00: one byte when `large_page_i` is 0, two bytes when it is 1.
- R3: When the page phase is present, the page bytes follow the column bytes: page bits 7:0 first, then bits 15:8.
- R4: When `high_density_i` is 1 and the page phase is present, a third page byte carrying page bits 23:16 follows the second page byte. When it is 0, no third byte is sent.
- R5: `col_absent_i`=1 removes the column bytes and `page_absent_i`=1 removes the page bytes. Each flag acts independently of the other.
- R6: `addr_last_o` is 1 on the final byte of a sequence only. This is the last column byte when no page phase follows.
- R7: When both phases are absent, `done_o` is high in the cycle after the start pulse is taken, and no byte is offered.
- R8: The first byte is offered in the cycle after start is taken. An offered byte and its last marker stay stable while `addr_ready_i` is low. The next byte appears only in the cycle after a transfer.
- R9: `done_o` is a single-cycle pulse in the cycle after the final byte's transfer. `addr_valid_o` is low in that cycle.
- R10: `busy_o` is high from the cycle after start is taken through the `done_o` cycle. A start pulse while `busy_o` is high is ignored.
- R11: The page number and flags are captured when start is taken. Changing them during a sequence does not alter the bytes emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a new address sequence; taken only when idle |
| col_absent_i | input | 1 | 1: skip the column phase |
| page_absent_i | input | 1 | 1: skip the page phase |
| large_page_i | input | 1 | 1: 2048-byte pages, 0: 512-byte pages |
| high_density_i | input | 1 | 1: send a third page byte |
| page_i | input | 24 | Page number for the page phase |
| addr_valid_o | output | 1 | An address byte is offered |
| addr_ready_i | input | 1 | Downstream latch accepts the offered byte |
| addr_byte_o | output | 8 | Address byte value |
| addr_last_o | output | 1 | Offered byte is the final one of the sequence |
| busy_o | output | 1 | A sequence is in progress; start is ignored |
| done_o | output | 1 | One-cycle pulse when the sequence completes |

## Verification
A corrupted byte index shows up at the stream on the very next offered byte. It appears as a wrong value, a missing or duplicated page byte, or a last marker on the wrong cycle. The bench's model compares every cycle, so the fault is reported at the first transfer after it. A state register stuck in the running or finished state is seen within one cycle: valid stays up when it should not, `done_o` stretches beyond one cycle, or `busy_o` fails to drop. Corrupted captured flags change the byte count, which the model flags when the extra byte or missing last marker appears.

// File: rtl/nand_addr_pkg.sv
package nand_addr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic col_skip;
    logic page_skip;
    logic big_page;
    logic dense;
  } seq_cfg_t;

endpackage

// File: rtl/nand_addr_plan.sv
module nand_addr_plan
  import nand_addr_pkg::*;
#(
  parameter int COL_SMALL = 1,
  parameter int COL_LARGE = 2,
  parameter int PG_BASE   = 2,
  parameter int PG_DENSE  = 3,
  parameter int CNT_W     = 3
) (
  input  seq_cfg_t         cfg_i,
  output logic [CNT_W-1:0] col_cnt_o,
  output logic [CNT_W-1:0] total_cnt_o
);

  logic [CNT_W-1:0] pg_cnt;

  always_comb begin
    if (cfg_i.col_skip)      col_cnt_o = '0;
    else if (cfg_i.big_page) col_cnt_o = CNT_W'(COL_LARGE);
    else                     col_cnt_o = CNT_W'(COL_SMALL);

    if (cfg_i.page_skip)     pg_cnt = '0;
    else if (cfg_i.dense)    pg_cnt = CNT_W'(PG_DENSE);
    else                     pg_cnt = CNT_W'(PG_BASE);

    total_cnt_o = col_cnt_o + pg_cnt;
  end

endmodule

// File: rtl/nand_addr_mux.sv
module nand_addr_mux #(
  parameter int PG_BYTES = 3,
  parameter int BYTE_W   = 8,
  parameter int CNT_W    = 3,
  localparam int PAGE_W  = PG_BYTES * BYTE_W
) (
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [CNT_W-1:0]  col_cnt_i,
  input  logic [CNT_W-1:0]  total_cnt_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              last_o
);

  logic [BYTE_W-1:0] slice [PG_BYTES];
  logic [CNT_W-1:0]  pg_idx;

  for (genvar g = 0; g < PG_BYTES; g++) begin : g_slice
    assign slice[g] = page_i[g*BYTE_W +: BYTE_W];
  end

  assign pg_idx = idx_i - col_cnt_i;

  always_comb begin
    byte_o = '0;
    if (idx_i >= col_cnt_i) begin
      for (int k = 0; k < PG_BYTES; k++) begin
        if (pg_idx == CNT_W'(k)) byte_o = slice[k];
      end
    end
  end

  assign last_o = (idx_i == total_cnt_i - CNT_W'(1));

endmodule

// File: rtl/nand_addr_ctrl.sv
module nand_addr_ctrl
  import nand_addr_pkg::*;
#(
  parameter int PAGE_W = 24,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  seq_cfg_t          cfg_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              ready_i,
  input  logic              last_i,
  output seq_cfg_t          cfg_q_o,
  output logic [PAGE_W-1:0] page_q_o,
  output logic [CNT_W-1:0]  idx_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              done_o
);

  seq_state_e state_q;
  logic       take;
  logic       xfer;

  assign take = start_i && (state_q == ST_IDLE);
  assign xfer = valid_o && ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_o    <= '0;
      cfg_q_o  <= '0;
      page_q_o <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (take) begin
            cfg_q_o  <= cfg_i;
            page_q_o <= page_i;
            idx_o    <= '0;
            state_q  <= (cfg_i.col_skip && cfg_i.page_skip) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (xfer) begin
            if (last_i) state_q <= ST_FIN;
            else        idx_o   <= idx_o + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign valid_o = (state_q == ST_RUN);
  assign done_o  = (state_q == ST_FIN);
  assign busy_o  = (state_q != ST_IDLE);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(xfer && last_i) ||
                       $past(start_i && cfg_i.col_skip && cfg_i.page_skip)));

  p_capture_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(page_q_o) && $stable(cfg_q_o)));

  p_busy_after_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
  import nand_addr_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int COL_SMALL = 1,
  parameter int COL_LARGE = 2,
  parameter int PG_BASE   = 2,
  parameter int PG_DENSE  = 3,
  localparam int PAGE_W   = PG_DENSE * BYTE_W,
  localparam int MAX_CYC  = COL_LARGE + PG_DENSE,
  localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              col_absent_i,
  input  logic              page_absent_i,
  input  logic              large_page_i,
  input  logic              high_density_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              addr_valid_o,
  input  logic              addr_ready_i,
  output logic [BYTE_W-1:0] addr_byte_o,
  output logic              addr_last_o,
  output logic              busy_o,
  output logic              done_o
);

  seq_cfg_t          cfg_in;
  seq_cfg_t          cfg_q;
  logic [PAGE_W-1:0] page_q;
  logic [CNT_W-1:0]  idx;
  logic [CNT_W-1:0]  col_cnt;
  logic [CNT_W-1:0]  total_cnt;

  assign cfg_in = '{col_skip: col_absent_i, page_skip: page_absent_i,
                    big_page: large_page_i, dense: high_density_i};

  nand_addr_ctrl #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cfg_i    (cfg_in),
    .page_i   (page_i),
    .ready_i  (addr_ready_i),
    .last_i   (addr_last_o),
    .cfg_q_o  (cfg_q),
    .page_q_o (page_q),
    .idx_o    (idx),
    .valid_o  (addr_valid_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  nand_addr_plan #(
    .COL_SMALL(COL_SMALL), .COL_LARGE(COL_LARGE),
    .PG_BASE(PG_BASE), .PG_DENSE(PG_DENSE), .CNT_W(CNT_W)
  ) u_plan (
    .cfg_i       (cfg_q),
    .col_cnt_o   (col_cnt),
    .total_cnt_o (total_cnt)
  );

  nand_addr_mux #(.PG_BYTES(PG_DENSE), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_mux (
    .idx_i       (idx),
    .col_cnt_i   (col_cnt),
    .total_cnt_i (total_cnt),
    .page_i      (page_q),
    .byte_o      (addr_byte_o),
    .last_o      (addr_last_o)
  );

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && !addr_ready_i) |=>
      (addr_valid_o && $stable(addr_byte_o) && $stable(addr_last_o)));

  p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && addr_ready_i && addr_last_o) |=> (!addr_valid_o && done_o));

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_valid_o && done_o));

  p_first_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !col_absent_i) |=> (addr_valid_o && addr_byte_o == '0));

endmodule

// File: tb/nand_addr_seq_bench.sv
`timescale 1ns/1ps
module nand_addr_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        col_absent_i = 1'b0;
  logic        page_absent_i = 1'b0;
  logic        large_page_i = 1'b0;
  logic        high_density_i = 1'b0;
  logic [23:0] page_i = '0;
  logic        addr_ready_i = 1'b0;
  logic        addr_valid_o;
  logic [7:0]  addr_byte_o;
  logic        addr_last_o;
  logic        busy_o;
  logic        done_o;

  always #4 clk = ~clk;

  nand_addr_seq u_nand_addr_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .col_absent_i(col_absent_i), .page_absent_i(page_absent_i),
    .large_page_i(large_page_i), .high_density_i(high_density_i),
    .page_i(page_i), .addr_valid_o(addr_valid_o), .addr_ready_i(addr_ready_i),
    .addr_byte_o(addr_byte_o), .addr_last_o(addr_last_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int checks = 0;
  int errors = 0;
  int m_state = 0;
  logic [7:0] exp_b[$];
  bit         exp_l[$];
  string      exp_t[$];
  string      run_tag = "";
  int         ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit          finished = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0;
      exp_b.delete(); exp_l.delete(); exp_t.delete();
    end else begin
      case (m_state)
        0: if (start_i) begin
          int cc;
          int pc;
          cc = col_absent_i ? 0 : (large_page_i ? 2 : 1);
          pc = page_absent_i ? 0 : (high_density_i ? 3 : 2);
          for (int i = 0; i < cc; i++) begin
            exp_b.push_back(8'h00);
            exp_t.push_back({page_absent_i ? "R5 " : "", "R2 ", run_tag});
          end
          for (int j = 0; j < pc; j++) begin
            exp_b.push_back(page_i[8*j +: 8]);
            exp_t.push_back({col_absent_i ? "R5 " : "", (j == 2) ? "R4 " : "R3 ", run_tag});
          end
          for (int k = 0; k < cc + pc; k++) exp_l.push_back(k == cc + pc - 1);
          m_state = (cc + pc == 0) ? 2 : 1;
        end
        1: if (addr_ready_i) begin
          void'(exp_b.pop_front()); void'(exp_l.pop_front()); void'(exp_t.pop_front());
          if (exp_b.size() == 0) m_state = 2;
        end
        default: m_state = 0;
      endcase
    end
  end

  // comparison every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check({"R8 valid ", run_tag}, addr_valid_o, m_state == 1);
      check({"R9 R7 done ", run_tag}, done_o, m_state == 2);
      check({"R10 busy ", run_tag}, busy_o, m_state != 0);
      if (m_state == 1 && exp_b.size() > 0) begin
        check({exp_t[0], " byte"}, addr_byte_o, exp_b[0]);
        check({"R6 last ", exp_t[0]}, addr_last_o, exp_l[0]);
      end
    end
  end

  // ready driver
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ready_mode)
      0: addr_ready_i <= 1'b1;
      1: addr_ready_i <= lfsr[0];
      default: addr_ready_i <= (lfsr[1:0] == 2'b00);
    endcase
  end

  task automatic run_seq(input bit cs, input bit ps, input bit lg, input bit hd,
                         input logic [23:0] pg, input bit poke, input string tag);
    run_tag = tag;
    @(negedge clk);
    col_absent_i = cs; page_absent_i = ps; large_page_i = lg; high_density_i = hd;
    page_i = pg; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      // R10 R11: second start and altered inputs while running
      start_i = 1'b1; page_i = ~pg; large_page_i = ~lg; high_density_i = ~hd;
      col_absent_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (m_state != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check("R1 reset valid", addr_valid_o, 0);
      check("R1 reset done", done_o, 0);
      check("R1 reset busy", busy_o, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset valid", addr_valid_o, 0);
    check("R1 after reset busy", busy_o, 0);

    ready_mode = 0;
    run_seq(0, 0, 0, 0, 24'h12A5C3, 0, "small");          // R2 R3
    run_seq(0, 0, 1, 0, 24'h0077F1, 0, "large");          // R2 R3
    ready_mode = 1;
    run_seq(0, 0, 1, 1, 24'hB46E29, 0, "large dense");    // R4 R8
    run_seq(0, 0, 0, 1, 24'h5D0C88, 0, "small dense");    // R4
    run_seq(1, 0, 0, 1, 24'h9E3317, 0, "R5 no column");
    run_seq(0, 1, 1, 1, 24'hFFFFFF, 0, "R5 no page large");   // R6
    run_seq(0, 1, 0, 0, 24'hFFFFFF, 0, "R5 no page small");
    run_seq(1, 1, 1, 1, 24'h123456, 0, "R7 empty");
    ready_mode = 2;
    run_seq(0, 0, 1, 1, 24'hC0FFEE, 1, "R10 R11 poke");
    run_seq(1, 1, 0, 0, 24'h000000, 0, "R7 empty stall");
    run_seq(0, 0, 0, 0, 24'h00A5FF, 1, "R11 poke small");
    for (int n = 0; n < 40; n++) begin
      ready_mode = n % 3;
      run_seq(lfsr[2], lfsr[3], lfsr[4], lfsr[5], {lfsr[7:0], lfsr, lfsr[15:8]} , 1'(n % 4 == 0),
              "R8 sweep");
    end
    // start held in done cycle and right after: only one sequence
    ready_mode = 0;
    run_tag = "R10 held start";
    @(negedge clk);
    col_absent_i = 1'b0; page_absent_i = 1'b0; large_page_i = 1'b0; high_density_i = 1'b0;
    page_i = 24'h00BEEF; start_i = 1'b1;
    repeat (5) @(negedge clk);
    start_i = 1'b0;
    while (m_state != 0) @(negedge clk);
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    finished = 1'b1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule